// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block keeps a handful of recent page mappings next to the processor so that most virtual addresses turn into physical addresses without a page-table access. A 14-bit virtual address arrives with a lookup strobe. One clock later the block reports whether the page was held. On a hit it also returns the 12-bit physical address. The page size is 64 bytes, so the low six address bits pass through translation untouched.

The 16 entries are arranged as four sets of four ways. Each entry holds a tag, a 6-bit frame number and a valid bit. All four ways of the selected set are compared in the same cycle. After a miss, the page walker outside this block supplies the mapping through the fill port. A fill reuses the way that already holds the same tag. Failing that, it takes the lowest-numbered empty way. Failing that, it takes the way named by a rotating pointer kept for each set. A flush strobe empties the whole buffer in one clock.

Top module: `xlat_cache`

## Requirements
- R1: While reset is asserted, and after it is released, `res_valid`, `res_hit` and `res_paddr` read 0. Every entry is invalid, so the first lookups miss.
- R2: Virtual address bits [7:6] select the set and bits [13:8] form the tag. The same tag in a different set does not hit.
- R3: A hit requires a valid entry in the selected set whose tag equals the address tag. On a miss `res_hit` is 0 and `res_paddr` is 0.
- R4: On a hit `res_paddr` equals the stored 6-bit frame number in bits [11:6], joined to virtual address bits [5:0] in bits [5:0].
- R5: `res_valid` is high in exactly the cycle after a cycle with `lk_req` high. `res_hit` is never high without `res_valid`.
- R6: A fill whose tag is not yet in the set writes the lowest-numbered invalid way of that set. The fill tag is `fill_vpn[7:2]` and the fill set is `fill_vpn[1:0]`.
- R7: When all four ways of the target set are valid, a fill replaces the way named by that set's pointer. The pointer starts at way 0 and advances by one, wrapping from 3 to 0, on each such replacement only.
- R8: A fill whose tag already matches a valid way of the set overwrites that way's frame number and allocates no second copy.
- R9: A flush clears every valid bit and every set's pointer in one cycle. When a flush and a fill arrive in the same cycle, the flush wins and the fill is dropped.
- R10: A lookup in the same cycle as a fill or a flush sees the contents from before that update.
- R11: Fills and replacements in one set leave the entries and the pointers of the other sets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup strobe |
| lk_vaddr | input | 14 | Virtual address to translate |
| res_valid | output | 1 | Response for the previous cycle's lookup |
| res_hit | output | 1 | Mapping was present |
| res_paddr | output | 12 | Physical address on a hit, else 0 |
| fill_en | input | 1 | Write one mapping |
| fill_vpn | input | 8 | Virtual page number of the mapping |
| fill_ppn | input | 6 | Frame number of the mapping |
| flush | input | 1 | Invalidate all entries |

## Verification
Directed lookups are run against empty, partly filled and full sets. They separate a tag match from a set match, and they show that the page offset passes through unchanged. The fill patterns each isolate one victim choice: filling one set to capacity and past it tests lowest-free allocation against pointer replacement, and a repeated tag tests overwrite against duplication. Lookups coinciding with fills and flushes, and a flush coinciding with a fill, show the ordering within a cycle. A long random mix over a small tag range then produces many hits, evictions and flushes, and every cycle is compared with a behavioural model.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_req,
  input  logic [VA_W-1:0]       lk_vaddr,
  output logic                  res_valid,
  output logic                  res_hit,
  output logic [PA_W-1:0]       res_paddr,
  input  logic                  fill_en,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic                  flush
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAY_W-1:0] rr_q  [SETS];

  logic [SET_W-1:0] lk_set, f_set;
  logic [TAG_W-1:0] lk_tag, f_tag;
  logic [WAYS-1:0]  lk_match, f_match;
  logic [PPN_W-1:0] lk_ppn;
  logic [WAY_W-1:0] f_way;
  logic             f_repl;
  logic             lk_hit;

  assign lk_set = lk_vaddr[OFF_W +: SET_W];
  assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
  assign f_set  = fill_vpn[SET_W-1:0];
  assign f_tag  = fill_vpn[VPN_W-1 -: TAG_W];
  assign lk_hit = |lk_match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign f_match[w]  = vld_q[f_set][w]  && (tag_q[f_set][w]  == f_tag);
  end

  always_comb begin
    lk_ppn = '0;
    for (int w = 0; w < WAYS; w++)
      if (lk_match[w]) lk_ppn = lk_ppn | ppn_q[lk_set][w];
  end

  always_comb begin
    f_way  = rr_q[f_set];
    f_repl = 1'b1;
    for (int w = WAYS-1; w >= 0; w--)
      if (!vld_q[f_set][w]) begin
        f_way  = WAY_W'(w);
        f_repl = 1'b0;
      end
    for (int w = 0; w < WAYS; w++)
      if (f_match[w]) begin
        f_way  = WAY_W'(w);
        f_repl = 1'b0;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_paddr <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          ppn_q[s][w] <= '0;
        end
      end
    end else begin
      res_valid <= lk_req;
      res_hit   <= lk_req && lk_hit;
      res_paddr <= (lk_req && lk_hit) ? {lk_ppn, lk_vaddr[OFF_W-1:0]} : '0;
      if (flush) begin
        for (int s = 0; s < SETS; s++) begin
          vld_q[s] <= '0;
          rr_q[s]  <= '0;
        end
      end else if (fill_en) begin
        vld_q[f_set][f_way] <= 1'b1;
        tag_q[f_set][f_way] <= f_tag;
        ppn_q[f_set][f_way] <= fill_ppn;
        if (f_repl) rr_q[f_set] <= rr_q[f_set] + WAY_W'(1);
      end
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_req,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            res_valid,
  input logic            res_hit,
  input logic [PA_W-1:0] res_paddr,
  input logic            flush
);
  p_resp_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> res_valid);
  p_no_resp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !res_valid);
  p_hit_has_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid);
  p_miss_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_paddr == '0));
  p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (!res_hit || res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 lk_req |=> !res_hit);
endmodule

bind xlat_cache xlat_cache_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
  .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr), .flush(flush)
);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [13:0] lk_vaddr = '0;
  logic        res_valid, res_hit;
  logic [11:0] res_paddr;
  logic        fill_en = 1'b0;
  logic [7:0]  fill_vpn = '0;
  logic [5:0]  fill_ppn = '0;
  logic        flush = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  bit m_vld [4][4];
  int m_tag [4][4];
  int m_ppn [4][4];
  int m_rr  [4];

  always #5 clk = ~clk;

  xlat_cache i_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush(flush)
  );

  function automatic logic [13:0] va(int tg, int st, int off);
    return {6'(tg), 2'(st), 6'(off)};
  endfunction

  task automatic check(string req, bit v, bit h, logic [11:0] pa);
    n_checks++;
    if (res_valid !== v || res_hit !== h || res_paddr !== pa) begin
      n_fail++;
      $display("FAIL %s: valid/hit/paddr = %0d/%0d/%h expected %0d/%0d/%h",
               req, res_valid, res_hit, res_paddr, v, h, pa);
    end
  endtask

  task automatic step(string req, bit rq, logic [13:0] a, bit fe,
                      int fvpn, int fppn, bit fl);
    bit eh = 0;
    logic [11:0] ep = '0;
    int s, t, way;
    lk_req = rq; lk_vaddr = a; fill_en = fe;
    fill_vpn = 8'(fvpn); fill_ppn = 6'(fppn); flush = fl;
    s = int'(a[7:6]); t = int'(a[13:8]);
    if (rq)
      for (int w = 0; w < 4; w++)
        if (m_vld[s][w] && m_tag[s][w] == t) begin
          eh = 1; ep = {6'(m_ppn[s][w]), a[5:0]};
        end
    if (fl) begin
      for (int i = 0; i < 4; i++) begin
        m_rr[i] = 0;
        for (int w = 0; w < 4; w++) m_vld[i][w] = 0;
      end
    end else if (fe) begin
      s = fvpn % 4; t = (fvpn / 4) % 64; way = -1;
      for (int w = 0; w < 4; w++) if (m_vld[s][w] && m_tag[s][w] == t) way = w;
      if (way < 0) for (int w = 3; w >= 0; w--) if (!m_vld[s][w]) way = w;
      if (way < 0) begin way = m_rr[s]; m_rr[s] = (m_rr[s] + 1) % 4; end
      m_vld[s][way] = 1; m_tag[s][way] = t; m_ppn[s][way] = fppn % 64;
    end
    @(negedge clk);
    check(req, rq, eh, ep);
  endtask

  task automatic look(string req, int tg, int st, int off);
    step(req, 1, va(tg, st, off), 0, 0, 0, 0);
  endtask

  task automatic fill(string req, int tg, int st, int pp);
    step(req, 0, '0, 1, tg * 4 + st, pp, 0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_rr[i] = 0;
      for (int w = 0; w < 4; w++) begin m_vld[i][w] = 0; m_tag[i][w] = 0; m_ppn[i][w] = 0; end
    end
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 0, 0, '0);
    look("R1 empty miss", 5, 1, 0);
    look("R3 miss", 5, 1, 7);
    fill("R6 first fill", 5, 1, 6'h2D);
    look("R4 hit paddr", 5, 1, 6'h13);
    look("R2 other set", 5, 2, 6'h13);
    look("R3 other tag", 6, 1, 6'h13);
    step("R5 idle", 0, '0, 0, 0, 0, 0);
    fill("R6 fill way1", 6, 1, 6'h11);
    fill("R6 fill way2", 7, 1, 6'h22);
    fill("R6 fill way3", 8, 1, 6'h33);
    look("R6 hit 6", 6, 1, 1);
    look("R6 hit 8", 8, 1, 63);
    fill("R7 replace way0", 9, 1, 6'h09);
    look("R7 evicted 5", 5, 1, 2);
    look("R7 new 9", 9, 1, 2);
    fill("R7 replace way1", 10, 1, 6'h0A);
    look("R7 evicted 6", 6, 1, 3);
    look("R7 kept 7", 7, 1, 3);
    look("R11 set0 untouched", 9, 0, 3);
    fill("R8 first", 3, 2, 1);
    fill("R8 same tag", 3, 2, 2);
    look("R8 overwritten", 3, 2, 4);
    fill("R8 fill 4", 4, 2, 4);
    fill("R8 fill 5", 5, 2, 5);
    fill("R8 fill 6", 6, 2, 6);
    look("R8 tag3 kept", 3, 2, 0);
    look("R8 tag6 present", 6, 2, 0);
    look("R11 set1 kept", 7, 1, 0);
    step("R10 lookup with fill", 1, va(1, 3, 5), 1, 1 * 4 + 3, 6'h3F, 0);
    look("R10 after fill", 1, 3, 5);
    step("R10 lookup with flush", 1, va(9, 1, 8), 0, 0, 0, 1);
    look("R9 flushed 9", 9, 1, 8);
    look("R9 flushed 3", 3, 2, 8);
    step("R9 flush beats fill", 1, va(2, 0, 0), 1, 2 * 4 + 0, 5, 1);
    look("R9 fill dropped", 2, 0, 0);
    for (int k = 0; k < 5; k++) fill("R9 refill", 20 + k, 0, 40 + k);
    look("R9 pointer reset way0", 20, 0, 1);
    look("R9 pointer reset new", 24, 0, 1);
    look("R7 way1 kept", 21, 0, 1);
    for (int k = 0; k < 3000; k++) begin
      int op = $urandom_range(0, 99);
      int tg = $urandom_range(0, 7);
      int st = $urandom_range(0, 3);
      step("R3 R6 R7 random", (op % 3) != 0, va(tg, st, $urandom_range(0, 63)),
           op < 45, $urandom_range(0, 7) * 4 + $urandom_range(0, 3),
           $urandom_range(0, 63), op == 99);
    end
    report();
  end
endmodule